// File: doc/BRIEF.md
# ATA PIO Single-Sector Transfer Engine

This block sits on the host side of an ATA/IDE link and moves one 512-byte sector between the drive and a page of a local 16-bit SRAM. It uses programmed I/O and 28-bit logical block addressing. A one-cycle request carries the direction, a drive select, an LBA and an SRAM page number. The engine then loads the task-file registers and issues the command. It polls the status register between accesses. Finally it streams 256 words with individual read or write strobes, each word going to or from consecutive SRAM locations.

A separate one-cycle request drives the drive's hardware reset line low for a fixed time. All strobe and reset durations are counted in clock cycles derived from the `CLK_HZ` parameter. `STROBE_NS` sets the strobe width (nominally 1 µs) and `RESET_US` sets the reset width (nominally 10 ms).

The controller has ten states. `S_IDLE` goes to `S_RST_HOLD` on a reset request, or to `S_TF_DRIVE` on a transfer request. `S_RST_HOLD` returns to `S_IDLE` when its timer expires. `S_TF_DRIVE` goes to `S_TF_STROBE`, which goes to `S_RECOVER` when its timer expires. `S_RECOVER` goes to `S_POLL`, which goes to `S_POLL_GAP` when its timer expires. From `S_POLL_GAP` the engine goes:
- back to `S_POLL` while BSY is set, or after the command while DRQ is still clear;
- to `S_TF_DRIVE` for the next task-file register;
- to `S_DATA_SETUP` for the next data word;
- to `S_FINISH` after the last word.

`S_DATA_SETUP` goes to `S_DATA_STROBE`, which goes to `S_RECOVER` when its timer expires. `S_FINISH` returns to `S_IDLE`.

Top module: `pio_sector_engine`

## Requirements
- R1: The LBA is masked to 28 bits. The device/head value is 0xE0 ORed with LBA[27:24] when `req_dev` is 0, 2 or 3, and 0xF0 ORed with LBA[27:24] when `req_dev` is 1.
- R2: The task-file writes come in this order, with these register addresses:
  1. address 6: device/head
  2. address 5: LBA[23:16]
  3. address 4: LBA[15:8]
  4. address 3: LBA[7:0]
  5. address 2: count 0x01
  6. address 7: the command, 0x20 for read or 0x30 for write
- R3: After every register, command or data access, the status register (address 7) is read with DIOR until bit 7 (BSY) reads 0. No further DIOR or DIOW access starts before that.
- R4: After the command, no data word moves until one status read shows BSY (bit 7) clear and DRQ (bit 3) set.
- R5: The data phase moves exactly `WORDS` (256) words at register address 0. SRAM addresses run from page×256 upward by one per word. No other SRAM location is written.
- R6: Every DIOR and DIOW pulse is low for exactly STROBE_CYC = CLK_HZ/1e6 × STROBE_NS/1000 cycles. On a read, each word gives one single-cycle `sram_we` inside its DIOR pulse, and `sram_wdata` equals the bus word.
- R7: On a write, the word at the current SRAM address is driven on `ata_dout` with `ata_doe` high for the whole DIOW pulse.
- R8: Register and command writes place their byte on bits 7:0, with bits 15:8 zero.
- R9: A reset request holds `ata_reset_n` low for exactly RESET_CYC = CLK_HZ/1e6 × RESET_US cycles. During that time both strobes stay high and the bus is not driven. A reset request wins over a simultaneous transfer request, which is then dropped.
- R10: `done` is a one-cycle pulse after the final status read. `error` equals bit 0 (ERR) of that read and holds until the next transfer. `busy` is high from acceptance until `done`.
- R11: After reset the outputs are idle: strobes high, `ata_reset_n` high, bus not driven, `busy` and `done` low. DIOR and DIOW are never low together, and the bus is driven only outside DIOR pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | One-cycle transfer request, taken in idle |
| req_write | input | 1 | 1 = SRAM to drive, 0 = drive to SRAM |
| req_dev | input | 2 | Drive select; only 1 selects the second drive |
| req_lba | input | 32 | Logical block address (upper 4 bits ignored) |
| req_page | input | PAGE_W | SRAM page number |
| reset_req | input | 1 | One-cycle hardware reset request, taken in idle |
| busy | output | 1 | Engine not idle |
| done | output | 1 | Transfer finished pulse |
| error | output | 1 | ERR bit of the final status read |
| ata_addr | output | 3 | Task-file register address |
| ata_dior_n | output | 1 | Read strobe, active low |
| ata_diow_n | output | 1 | Write strobe, active low |
| ata_reset_n | output | 1 | Drive hardware reset, active low |
| ata_dout | output | 16 | Bus data toward the drive |
| ata_doe | output | 1 | Bus output enable |
| ata_din | input | 16 | Bus data from the drive |
| sram_addr | output | PAGE_W+log2(WORDS) | SRAM word address |
| sram_we | output | 1 | SRAM write strobe |
| sram_wdata | output | 16 | SRAM write data |
| sram_rdata | input | 16 | SRAM read data (combinational) |

## Verification
A drive model answers status reads and can hold BSY for 0 to 2 extra reads after each access. After the command it can also hold DRQ low for extra reads, and it raises ERR only once the last word has moved. The exact count of status reads then tells correct polling apart from skipped or surplus polling. Per-word patterns and address-derived SRAM contents show misordered, shifted or stray words. The sweep covers all four drive-select codes and both directions. It includes an LBA with its top nibble set, to show the masking and the device/head value. A combined reset-and-transfer request shows which one wins.

// File: rtl/pio_sector_pkg.sv
package pio_sector_pkg;

    localparam int BUS_W = 16;

    // Task-file register addresses decoded by the drive
    localparam logic [2:0] REG_DATA    = 3'd0;
    localparam logic [2:0] REG_COUNT   = 3'd2;
    localparam logic [2:0] REG_LBA_LO  = 3'd3;
    localparam logic [2:0] REG_LBA_MID = 3'd4;
    localparam logic [2:0] REG_LBA_HI  = 3'd5;
    localparam logic [2:0] REG_SELECT  = 3'd6;
    localparam logic [2:0] REG_STATCMD = 3'd7;

    localparam logic [7:0] OP_READ  = 8'h20;
    localparam logic [7:0] OP_WRITE = 8'h30;

    localparam int BIT_BSY = 7;
    localparam int BIT_DRQ = 3;
    localparam int BIT_ERR = 0;

    localparam logic [2:0] STEP_CMD = 3'd5;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RST_HOLD,
        S_TF_DRIVE,
        S_TF_STROBE,
        S_RECOVER,
        S_POLL,
        S_POLL_GAP,
        S_DATA_SETUP,
        S_DATA_STROBE,
        S_FINISH
    } eng_state_t;

endpackage

// File: rtl/pio_cycle_timer.sv
module pio_cycle_timer #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    output logic             last
);
    logic [WIDTH-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign last = (cnt_q == '0);
endmodule

// File: rtl/pio_taskfile_rom.sv
module pio_taskfile_rom
    import pio_sector_pkg::*;
(
    input  logic [2:0]  step,
    input  logic [27:0] lba,
    input  logic        dev_hi,
    input  logic        wr,
    output logic [2:0]  reg_addr,
    output logic [7:0]  reg_val
);
    always_comb begin
        unique case (step)
            3'd0: begin
                reg_addr = REG_SELECT;
                reg_val  = {3'b111, dev_hi, lba[27:24]};
            end
            3'd1: begin
                reg_addr = REG_LBA_HI;
                reg_val  = lba[23:16];
            end
            3'd2: begin
                reg_addr = REG_LBA_MID;
                reg_val  = lba[15:8];
            end
            3'd3: begin
                reg_addr = REG_LBA_LO;
                reg_val  = lba[7:0];
            end
            3'd4: begin
                reg_addr = REG_COUNT;
                reg_val  = 8'h01;
            end
            default: begin
                reg_addr = REG_STATCMD;
                reg_val  = wr ? OP_WRITE : OP_READ;
            end
        endcase
    end
endmodule

// File: rtl/pio_word_counter.sv
module pio_word_counter #(
    parameter int PAGE_W = 4,
    parameter int IDX_W  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic [PAGE_W-1:0]       page,
    input  logic                    advance,
    output logic [PAGE_W+IDX_W-1:0] addr,
    output logic                    all_done
);
    localparam logic [IDX_W:0] FULL = {1'b1, {IDX_W{1'b0}}};

    logic [PAGE_W-1:0] page_q;
    logic [IDX_W:0]    cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q <= '0;
            cnt_q  <= '0;
        end else if (clear) begin
            page_q <= page;
            cnt_q  <= '0;
        end else if (advance) begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign addr     = {page_q, cnt_q[IDX_W-1:0]};
    assign all_done = (cnt_q == FULL);
endmodule

// File: rtl/pio_sector_engine.sv
module pio_sector_engine
    import pio_sector_pkg::*;
#(
    parameter int CLK_HZ    = 50_000_000,
    parameter int STROBE_NS = 1000,
    parameter int RESET_US  = 10_000,
    parameter int PAGE_W    = 4,
    parameter int WORDS     = 256
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 req_valid,
    input  logic                                 req_write,
    input  logic [1:0]                           req_dev,
    input  logic [31:0]                          req_lba,
    input  logic [PAGE_W-1:0]                    req_page,
    input  logic                                 reset_req,
    output logic                                 busy,
    output logic                                 done,
    output logic                                 error,
    output logic [2:0]                           ata_addr,
    output logic                                 ata_dior_n,
    output logic                                 ata_diow_n,
    output logic                                 ata_reset_n,
    output logic [15:0]                          ata_dout,
    output logic                                 ata_doe,
    input  logic [15:0]                          ata_din,
    output logic [PAGE_W+$clog2(WORDS)-1:0]      sram_addr,
    output logic                                 sram_we,
    output logic [15:0]                          sram_wdata,
    input  logic [15:0]                          sram_rdata
);
    localparam int CYC_PER_US = CLK_HZ / 1_000_000;
    localparam int STROBE_RAW = CYC_PER_US * STROBE_NS / 1000;
    localparam int STROBE_CYC = (STROBE_RAW < 1) ? 1 : STROBE_RAW;
    localparam int RESET_RAW  = CYC_PER_US * RESET_US;
    localparam int RESET_CYC  = (RESET_RAW < 1) ? 1 : RESET_RAW;
    localparam int TMR_W      = $clog2(RESET_CYC + 1);
    localparam int IDX_W      = $clog2(WORDS);

    eng_state_t state_q, state_d;

    logic        wr_q, dev_hi_q, in_data_q, error_q;
    logic [27:0] lba_q;
    logic [2:0]  step_q;
    logic        st_bsy_q, st_drq_q, st_err_q;
    logic        lba_top_unused;

    logic        tmr_load, tmr_last;
    logic [TMR_W-1:0] tmr_val;
    logic [2:0]  tf_addr;
    logic [7:0]  tf_val;
    logic        words_all;
    logic        accept;

    assign lba_top_unused = ^req_lba[31:28];
    assign accept = (state_q == S_IDLE) && !reset_req && req_valid;

    pio_cycle_timer #(.WIDTH(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .last     (tmr_last)
    );

    pio_taskfile_rom u_tf_rom (
        .step     (step_q),
        .lba      (lba_q),
        .dev_hi   (dev_hi_q),
        .wr       (wr_q),
        .reg_addr (tf_addr),
        .reg_val  (tf_val)
    );

    pio_word_counter #(.PAGE_W(PAGE_W), .IDX_W(IDX_W)) u_words (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (accept),
        .page     (req_page),
        .advance  ((state_q == S_DATA_STROBE) && tmr_last),
        .addr     (sram_addr),
        .all_done (words_all)
    );

    // Timer reloads on every state change
    assign tmr_load = (state_d != state_q);
    assign tmr_val  = (state_d == S_RST_HOLD) ? TMR_W'(RESET_CYC - 1)
                                              : TMR_W'(STROBE_CYC - 1);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (reset_req)      state_d = S_RST_HOLD;
                else if (req_valid) state_d = S_TF_DRIVE;
            end
            S_RST_HOLD:    if (tmr_last) state_d = S_IDLE;
            S_TF_DRIVE:    state_d = S_TF_STROBE;
            S_TF_STROBE:   if (tmr_last) state_d = S_RECOVER;
            S_RECOVER:     state_d = S_POLL;
            S_POLL:        if (tmr_last) state_d = S_POLL_GAP;
            S_POLL_GAP: begin
                if (st_bsy_q)               state_d = S_POLL;
                else if (in_data_q)         state_d = words_all ? S_FINISH : S_DATA_SETUP;
                else if (step_q != STEP_CMD) state_d = S_TF_DRIVE;
                else if (st_drq_q)          state_d = S_DATA_SETUP;
                else                        state_d = S_POLL;
            end
            S_DATA_SETUP:  state_d = S_DATA_STROBE;
            S_DATA_STROBE: if (tmr_last) state_d = S_RECOVER;
            S_FINISH:      state_d = S_IDLE;
            default:       state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Request, step and status registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q      <= 1'b0;
            dev_hi_q  <= 1'b0;
            lba_q     <= '0;
            step_q    <= '0;
            in_data_q <= 1'b0;
            error_q   <= 1'b0;
            st_bsy_q  <= 1'b0;
            st_drq_q  <= 1'b0;
            st_err_q  <= 1'b0;
        end else begin
            if (accept) begin
                wr_q      <= req_write;
                dev_hi_q  <= (req_dev == 2'd1);
                lba_q     <= req_lba[27:0];
                step_q    <= '0;
                in_data_q <= 1'b0;
                error_q   <= 1'b0;
            end
            if ((state_q == S_POLL) && tmr_last) begin
                st_bsy_q <= ata_din[BIT_BSY];
                st_drq_q <= ata_din[BIT_DRQ];
                st_err_q <= ata_din[BIT_ERR];
            end
            if ((state_q == S_POLL_GAP) && !st_bsy_q) begin
                if (in_data_q) begin
                    if (words_all) error_q <= st_err_q;
                end else if (step_q != STEP_CMD) begin
                    step_q <= step_q + 1'b1;
                end else if (st_drq_q) begin
                    in_data_q <= 1'b1;
                end
            end
        end
    end

    // Outputs
    always_comb begin
        ata_addr   = REG_DATA;
        ata_dior_n = 1'b1;
        ata_diow_n = 1'b1;
        ata_doe    = 1'b0;
        ata_dout   = '0;
        sram_we    = 1'b0;
        unique case (state_q)
            S_TF_DRIVE, S_TF_STROBE: begin
                ata_addr   = tf_addr;
                ata_doe    = 1'b1;
                ata_dout   = {8'h00, tf_val};
                ata_diow_n = (state_q != S_TF_STROBE);
            end
            S_RECOVER, S_POLL, S_POLL_GAP: begin
                ata_addr   = REG_STATCMD;
                ata_dior_n = (state_q != S_POLL);
            end
            S_DATA_SETUP, S_DATA_STROBE: begin
                ata_addr = REG_DATA;
                if (wr_q) begin
                    ata_doe    = 1'b1;
                    ata_dout   = sram_rdata;
                    ata_diow_n = (state_q != S_DATA_STROBE);
                end else begin
                    ata_dior_n = (state_q != S_DATA_STROBE);
                    sram_we    = (state_q == S_DATA_STROBE) && tmr_last;
                end
            end
            default: begin
                ata_addr = REG_DATA;
            end
        endcase
    end

    assign ata_reset_n = (state_q != S_RST_HOLD);
    assign busy        = (state_q != S_IDLE);
    assign done        = (state_q == S_FINISH);
    assign error       = error_q;
    assign sram_wdata  = ata_din;
endmodule

// File: rtl/pio_sector_checker.sv
module pio_sector_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        done,
    input logic [2:0]  ata_addr,
    input logic        ata_dior_n,
    input logic        ata_diow_n,
    input logic        ata_reset_n,
    input logic        ata_doe,
    input logic [15:0] ata_dout,
    input logic        sram_we
);
    assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ata_dior_n && !ata_diow_n));

    assert_no_drive_on_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !ata_dior_n |-> !ata_doe);

    assert_drive_on_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !ata_diow_n |-> ata_doe);

    assert_we_in_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sram_we |-> (!ata_dior_n && ata_addr == 3'd0));

    assert_byte_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ata_diow_n && ata_addr != 3'd0) |-> (ata_dout[15:8] == 8'h00));

    assert_reset_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ata_reset_n |-> (ata_dior_n && ata_diow_n && !ata_doe && busy));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));
endmodule

bind pio_sector_engine pio_sector_checker u_pio_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .done        (done),
    .ata_addr    (ata_addr),
    .ata_dior_n  (ata_dior_n),
    .ata_diow_n  (ata_diow_n),
    .ata_reset_n (ata_reset_n),
    .ata_doe     (ata_doe),
    .ata_dout    (ata_dout),
    .sram_we     (sram_we)
);

// File: tb/test_pio_sector_engine.sv
`timescale 1ns/1ps
module test_pio_sector_engine;
    localparam int PAGE_W  = 2;
    localparam int WORDS   = 256;
    localparam int STROBE  = 4;
    localparam int RST_CYC = 40000;
    localparam int MEM_N   = WORDS << PAGE_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0, reset_req = 1'b0;
    logic [1:0] req_dev = '0;
    logic [31:0] req_lba = '0;
    logic [PAGE_W-1:0] req_page = '0;
    logic busy, done, error;
    logic [2:0] ata_addr;
    logic ata_dior_n, ata_diow_n, ata_reset_n, ata_doe;
    logic [15:0] ata_dout, ata_din;
    logic [PAGE_W+7:0] sram_addr;
    logic sram_we;
    logic [15:0] sram_wdata, sram_rdata;

    always #10 clk = ~clk;

    pio_sector_engine #(
        .CLK_HZ(4_000_000), .STROBE_NS(1000), .RESET_US(10_000),
        .PAGE_W(PAGE_W), .WORDS(WORDS)
    ) i_pio_sector_engine (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_dev(req_dev), .req_lba(req_lba), .req_page(req_page), .reset_req(reset_req),
        .busy(busy), .done(done), .error(error), .ata_addr(ata_addr),
        .ata_dior_n(ata_dior_n), .ata_diow_n(ata_diow_n), .ata_reset_n(ata_reset_n),
        .ata_dout(ata_dout), .ata_doe(ata_doe), .ata_din(ata_din),
        .sram_addr(sram_addr), .sram_we(sram_we), .sram_wdata(sram_wdata),
        .sram_rdata(sram_rdata)
    );

    int checks = 0, errors = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] pat(input logic [15:0] s, input int i);
        return s ^ (16'(i) * 16'h0101);
    endfunction

    function automatic logic [15:0] sentinel(input int a);
        return 16'(a) ^ 16'hA5A5;
    endfunction

    // ---------------- drive and SRAM model ----------------
    logic model_rst = 1'b0;
    int cfg_bsy = 0, cfg_drq = 0;
    bit cfg_err = 1'b0;
    logic [15:0] cfg_seed = '0;

    logic [15:0] mem [MEM_N];
    logic [15:0] dev_wbuf [WORDS];
    logic [2:0]  log_addr [8];
    logic [15:0] log_data [8];
    int log_n = 0, wr_idx = 0, rd_idx = 0, busy_left = 0, drq_hold = 0;
    int data_left = 0, polls = 0, viol = 0, we_n = 0, width_err = 0;
    int wlow = 0, dlow = 0;
    bit cmd_seen = 1'b0;
    logic prev_diow = 1'b1, prev_dior = 1'b1;
    logic [2:0] cap_waddr = '0, cap_raddr = '0;
    logic [15:0] cap_wdata = '0;
    logic drq_c, err_c;

    assign drq_c = cmd_seen && (busy_left == 0) && (drq_hold == 0) && (data_left != 0);
    assign err_c = cfg_err && cmd_seen && (data_left == 0);
    assign ata_din = (ata_addr == 3'd7) ? {8'h00, (busy_left != 0), 1'b1, 2'b00, drq_c, 2'b00, err_c}
                   : (ata_addr == 3'd0) ? pat(cfg_seed, rd_idx) : 16'h0000;
    assign sram_rdata = mem[sram_addr];

    always @(negedge clk) begin
        if (model_rst) begin
            log_n = 0; wr_idx = 0; rd_idx = 0; busy_left = 0; drq_hold = 0;
            data_left = 0; polls = 0; viol = 0; we_n = 0; width_err = 0;
            wlow = 0; dlow = 0; cmd_seen = 1'b0; prev_diow = 1'b1; prev_dior = 1'b1;
            for (int a = 0; a < MEM_N; a++) mem[a] = sentinel(a);
            for (int i = 0; i < WORDS; i++) dev_wbuf[i] = 16'h0000;
        end else if (rst_n) begin
            if (sram_we) begin
                mem[sram_addr] = sram_wdata;
                we_n++;
            end
            if (!ata_diow_n) begin
                if (prev_diow && (busy_left != 0 || (ata_addr == 3'd0 && !drq_c))) viol++;
                cap_waddr = ata_addr;
                cap_wdata = ata_dout;
                wlow++;
            end else if (!prev_diow) begin
                if (wlow != STROBE) width_err++;
                wlow = 0;
                if (cap_waddr == 3'd0) begin
                    if (wr_idx < WORDS) dev_wbuf[wr_idx] = cap_wdata;
                    wr_idx++;
                    if (data_left != 0) data_left--;
                end else begin
                    if (log_n < 8) begin
                        log_addr[log_n] = cap_waddr;
                        log_data[log_n] = cap_wdata;
                    end
                    log_n++;
                    if (cap_waddr == 3'd7) begin
                        cmd_seen = 1'b1;
                        data_left = WORDS;
                        drq_hold = cfg_drq;
                    end
                end
                busy_left = cfg_bsy;
            end
            if (!ata_dior_n) begin
                if (prev_dior && ata_addr == 3'd0 && !drq_c) viol++;
                if (prev_dior && busy_left != 0 && ata_addr != 3'd7) viol++;
                cap_raddr = ata_addr;
                dlow++;
            end else if (!prev_dior) begin
                if (dlow != STROBE) width_err++;
                dlow = 0;
                if (cap_raddr == 3'd7) begin
                    polls++;
                    if (busy_left != 0) busy_left--;
                    else if (drq_hold != 0) drq_hold--;
                end else if (cap_raddr == 3'd0) begin
                    rd_idx++;
                    if (data_left != 0) data_left--;
                    busy_left = cfg_bsy;
                end
            end
            prev_diow = ata_diow_n;
            prev_dior = ata_dior_n;
        end
    end

    task automatic clear_model(input int b, input int d, input bit e, input logic [15:0] seed);
        @(posedge clk);
        cfg_bsy = b; cfg_drq = d; cfg_err = e; cfg_seed = seed;
        model_rst = 1'b1;
        @(posedge clk);
        model_rst = 1'b0;
    endtask

    task automatic do_xfer(input bit wr, input logic [1:0] dev, input logic [31:0] lba,
                           input logic [PAGE_W-1:0] page, input logic [15:0] seed,
                           input int b, input int d, input bit e);
        logic [7:0] exp_val [6];
        logic [2:0] exp_addr [6];
        int guard, mism, exp_polls, base;
        clear_model(b, d, e, seed);
        @(negedge clk);
        req_write = wr; req_dev = dev; req_lba = lba; req_page = page; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy == 1'b1, "R10 busy after accept", 64'(busy), 64'd1);
        guard = 0;
        while (!done && guard < 30000) begin
            @(negedge clk);
            guard++;
        end
        chk(done == 1'b1, "R10 done reached", 64'(done), 64'd1);
        chk(error == e, "R10 error equals final ERR", 64'(error), 64'(e));
        @(negedge clk);
        chk(!done && !busy, "R10 done single cycle then idle", {62'd0, done, busy}, 64'd0);
        chk(error == e, "R10 error held", 64'(error), 64'(e));
        @(posedge clk);
        exp_addr[0] = 3'd6; exp_val[0] = ((dev == 2'd1) ? 8'hF0 : 8'hE0) | {4'h0, lba[27:24]};
        exp_addr[1] = 3'd5; exp_val[1] = lba[23:16];
        exp_addr[2] = 3'd4; exp_val[2] = lba[15:8];
        exp_addr[3] = 3'd3; exp_val[3] = lba[7:0];
        exp_addr[4] = 3'd2; exp_val[4] = 8'h01;
        exp_addr[5] = 3'd7; exp_val[5] = wr ? 8'h30 : 8'h20;
        chk(log_n == 6, "R2 register write count", 64'(log_n), 64'd6);
        chk(log_data[0] == {8'h00, exp_val[0]}, "R1 device/head value", 64'(log_data[0]), 64'(exp_val[0]));
        for (int k = 0; k < 6; k++) begin
            chk(log_addr[k] == exp_addr[k], "R2 register order", 64'(log_addr[k]), 64'(exp_addr[k]));
            chk(log_data[k] == {8'h00, exp_val[k]}, "R8 R2 register byte on low lane",
                64'(log_data[k]), 64'(exp_val[k]));
        end
        exp_polls = 5 * (b + 1) + (b + 1 + d) + WORDS * (b + 1);
        chk(polls == exp_polls, "R3 R4 status read count", 64'(polls), 64'(exp_polls));
        chk(viol == 0, "R3 R4 access while busy or before DRQ", 64'(viol), 64'd0);
        chk(width_err == 0, "R6 strobe width", 64'(width_err), 64'd0);
        base = int'(page) * WORDS;
        mism = 0;
        if (wr) begin
            chk(wr_idx == WORDS, "R5 words written to drive", 64'(wr_idx), 64'(WORDS));
            chk(we_n == 0, "R5 no SRAM write on drive write", 64'(we_n), 64'd0);
            for (int i = 0; i < WORDS; i++)
                if (dev_wbuf[i] != sentinel(base + i)) mism++;
            chk(mism == 0, "R7 drive received SRAM page", 64'(mism), 64'd0);
        end else begin
            chk(rd_idx == WORDS, "R5 words read from drive", 64'(rd_idx), 64'(WORDS));
            chk(we_n == WORDS, "R6 one SRAM strobe per word", 64'(we_n), 64'(WORDS));
            for (int a = 0; a < MEM_N; a++) begin
                if (a >= base && a < base + WORDS) begin
                    if (mem[a] != pat(seed, a - base)) mism++;
                end else if (mem[a] != sentinel(a)) begin
                    mism++;
                end
            end
            chk(mism == 0, "R5 R6 SRAM page contents", 64'(mism), 64'd0);
        end
    endtask

    task automatic do_reset_pulse(input bit with_req);
        int low_n, bad, guard;
        bit seen;
        clear_model(0, 0, 1'b0, 16'h0);
        @(negedge clk);
        reset_req = 1'b1;
        req_valid = with_req;
        req_write = 1'b0;
        @(negedge clk);
        reset_req = 1'b0;
        req_valid = 1'b0;
        low_n = 0; bad = 0; guard = 0; seen = 1'b0;
        while (guard < 60000 && !(seen && ata_reset_n)) begin
            if (!ata_reset_n) begin
                seen = 1'b1;
                low_n++;
                if (ata_doe || !ata_dior_n || !ata_diow_n) bad++;
            end
            @(negedge clk);
            guard++;
        end
        chk(low_n == RST_CYC, "R9 reset low duration", 64'(low_n), 64'(RST_CYC));
        chk(bad == 0, "R9 bus quiet during reset", 64'(bad), 64'd0);
        repeat (50) @(negedge clk);
        chk(!busy, "R9 idle after reset", 64'(busy), 64'd0);
        if (with_req) chk(log_n == 0, "R9 reset wins over request", 64'(log_n), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !done && ata_reset_n && ata_dior_n && ata_diow_n && !ata_doe,
            "R11 idle outputs in reset",
            {58'd0, busy, done, ata_reset_n, ata_dior_n, ata_diow_n, ata_doe}, 64'b001110);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!busy && !done && !error && ata_reset_n && ata_dior_n && ata_diow_n && !ata_doe,
            "R11 idle outputs after reset",
            {57'd0, busy, done, error, ata_reset_n, ata_dior_n, ata_diow_n, ata_doe}, 64'b0001110);

        do_xfer(1'b0, 2'd0, 32'h0000_0000, 2'd0, 16'h1111, 0, 0, 1'b0);
        do_xfer(1'b0, 2'd1, 32'hFFFF_FFFF, 2'd3, 16'hBEEF, 2, 1, 1'b1);
        do_xfer(1'b1, 2'd2, 32'h1A2B_3C4D, 2'd1, 16'h0000, 1, 2, 1'b0);
        do_xfer(1'b1, 2'd3, 32'h0765_4321, 2'd2, 16'h0000, 0, 0, 1'b1);
        do_xfer(1'b0, 2'd1, 32'h3F00_00FF, 2'd2, 16'h5A0F, 1, 0, 1'b0);
        do_reset_pulse(1'b1);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R10 watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule